// File: doc/BRIEF.md
# Key-Guarded Priority Grouping Controller

This block holds one 32-bit control word that can only be changed by a privileged write that carries a fixed unlock key in its upper halfword. The word carries a 3-bit grouping selector, which sets a binary point inside each 8-bit interrupt priority field. Only the top three bits of each field are implemented. The selector decides how many of those three bits count as group priority and how many count as subpriority. The same word also carries three write-only request bits. A keyed write turns each set request bit into a one-cycle pulse: vector reset, clear of active exception state, or system reset request.

The block applies the current split to all four lanes of a packed priority word and reports group and subpriority values for each lane, zero-extended to three bits. It also compares the group parts of a pending priority and an active priority, and raises a preemption flag only when the pending group is strictly lower. All outputs except the request pulses are combinational from the stored selector and the inputs. There is no data stream here, so there is no valid/ready handshake. The register port is a plain single-cycle select/write strobe that never stalls, and the priority inputs are sampled as levels.

Top module: `prio_group_ctrl`

## Requirements
- R1: A write (reg_sel=1, reg_wr=1) changes state only when reg_priv=1 and reg_wdata[31:16]=0x05FA. Any other key leaves the selector unchanged and raises no request pulse.
- R2: A privileged read (reg_sel=1, reg_priv=1) returns 0xFA05 in bits 31:16 and the selector in bits 10:8. All other bits read 0, including bit 15 (little-endian indication), bits 14:11 and the request bits 2:0.
- R3: An unprivileged write is ignored, and an unprivileged read returns 0.
- R4: After reset the selector is 0 and a privileged read returns 0xFA05_0000.
- R5: Selector values 0 to 4 make all three implemented bits [7:5] the group value, and the subpriority is 0.
- R6: Selector 5 gives group {0,p[7:6]} and subpriority {00,p[5]}. Selector 6 gives group {00,p[7]} and subpriority {0,p[6:5]}.
- R7: Selector 7 gives group 0 and subpriority p[7:5]. In this setting preempt stays low for all inputs.
- R8: Lane i of prio_word uses bits 8i+7:8i+5 and drives grp_word[3i+2:3i] and sub_word[3i+2:3i]. The bits below 8i+5 have no effect.
- R9: preempt is 1 exactly when pend_valid=1, act_valid=1 and the pending group value is numerically lower than the active one. Equal groups never preempt, whatever the subpriorities.
- R10: A keyed write with wdata bit 0, 1 or 2 set raises vect_rst_pulse, clr_act_pulse or sys_rst_req respectively, high for the one cycle that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register selected by address decode |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_priv | input | 1 | Access is from privileged mode |
| reg_wdata | input | 32 | Write data including key halfword |
| reg_rdata | output | 32 | Read data |
| prio_word | input | 32 | Four packed 8-bit priority fields |
| grp_word | output | 12 | Per-lane group priority, 3 bits each |
| sub_word | output | 12 | Per-lane subpriority, 3 bits each |
| pend_valid | input | 1 | A pending exception is presented |
| pend_prio | input | 8 | Priority field of the pending exception |
| act_valid | input | 1 | An exception is active |
| act_prio | input | 8 | Priority field of the active exception |
| preempt | output | 1 | Pending exception may preempt the active one |
| vect_rst_pulse | output | 1 | One-cycle vector reset request |
| clr_act_pulse | output | 1 | One-cycle clear-active request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is a priority pair whose full fields differ but whose group parts tie. That only happens after a keyed write has moved the binary point, so that the differing bit falls into the subpriority. The stimulus table therefore pairs each priority pair with a selector value. Before each comparison, a keyed write programs that selector, and then the pair is applied. Several table rows differ only below the binary point. Unkeyed and unprivileged writes are placed between keyed ones, and the selector is then read back to show that it held.

// File: rtl/prio_group_pkg.sv
package prio_group_pkg;
  localparam logic [15:0] WR_KEY = 16'h05FA;
  localparam logic [15:0] RD_KEY = 16'hFA05;
  localparam int          SEL_W  = 3;

  typedef struct packed {
    logic sys_req;
    logic clr_act;
    logic vect_rst;
  } strobe_t;
endpackage

// File: rtl/pg_ctrl_reg.sv
module pg_ctrl_reg
  import prio_group_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_priv,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [SEL_W-1:0] grouping,
  output strobe_t          strobe
);
  logic wr_ok;
  logic unused_wbits;

  assign wr_ok = reg_sel & reg_wr & reg_priv & (reg_wdata[31:16] == WR_KEY);
  assign unused_wbits = ^{reg_wdata[15:11], reg_wdata[7:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grouping <= '0;
      strobe   <= '0;
    end else begin
      strobe <= wr_ok ? strobe_t'(reg_wdata[2:0]) : '0;
      if (wr_ok) grouping <= reg_wdata[10:8];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && reg_priv) reg_rdata = {RD_KEY, 5'b0, grouping, 8'b0};
  end

  // R1: wrong key leaves state untouched
  a_r1_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_wdata[31:16] != WR_KEY) |=> ($stable(grouping) && strobe == '0));

  // R3: unprivileged write leaves state untouched
  a_r3_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && !reg_priv) |=> ($stable(grouping) && strobe == '0));

  // R10: a pulse only follows a privileged write
  a_r10_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '0) |-> $past(reg_sel && reg_wr && reg_priv));
endmodule

// File: rtl/pg_lane_split.sv
module pg_lane_split
  import prio_group_pkg::*;
#(
  parameter int PB = 3
) (
  input  logic [SEL_W-1:0] grouping,
  input  logic [PB-1:0]    prio,
  output logic [PB-1:0]    grp,
  output logic [PB-1:0]    sub
);
  localparam int LOW = 8 - PB;

  logic [3:0] bp;
  logic [3:0] sub_n;

  always_comb begin
    bp    = {1'b0, grouping} + 4'd1;
    sub_n = (bp > 4'(LOW)) ? (bp - 4'(LOW)) : 4'd0;
    grp   = prio >> sub_n;
    sub   = prio & ~({PB{1'b1}} << sub_n);
  end
endmodule

// File: rtl/pg_preempt_cmp.sv
module pg_preempt_cmp #(
  parameter int PB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_valid,
  input  logic          act_valid,
  input  logic [PB-1:0] pend_grp,
  input  logic [PB-1:0] act_grp,
  output logic          preempt
);
  assign preempt = pend_valid & act_valid & (pend_grp < act_grp);

  // R9: a group tie never preempts
  a_r9_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_grp == act_grp) |-> !preempt);

  // R9: both sides must be present
  a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_valid || !act_valid) |-> !preempt);
endmodule

// File: rtl/prio_group_ctrl.sv
module prio_group_ctrl
  import prio_group_pkg::*;
#(
  parameter int PB    = 3,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_sel,
  input  logic                  reg_wr,
  input  logic                  reg_priv,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [8*LANES-1:0]    prio_word,
  output logic [PB*LANES-1:0]   grp_word,
  output logic [PB*LANES-1:0]   sub_word,
  input  logic                  pend_valid,
  input  logic [7:0]            pend_prio,
  input  logic                  act_valid,
  input  logic [7:0]            act_prio,
  output logic                  preempt,
  output logic                  vect_rst_pulse,
  output logic                  clr_act_pulse,
  output logic                  sys_rst_req
);
  logic [SEL_W-1:0] grouping;
  strobe_t          strobe;
  logic [PB-1:0]    pend_grp, act_grp, pend_sub_unused, act_sub_unused;
  logic             unused_low;

  assign unused_low = ^{pend_prio[7-PB:0], act_prio[7-PB:0]};

  pg_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_priv(reg_priv), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grouping(grouping), .strobe(strobe)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic unused_lane_low;
    assign unused_lane_low = ^prio_word[8*i+7-PB:8*i];
    pg_lane_split #(.PB(PB)) u_split (
      .grouping(grouping),
      .prio(prio_word[8*i+7 -: PB]),
      .grp(grp_word[PB*i +: PB]),
      .sub(sub_word[PB*i +: PB])
    );
  end

  pg_lane_split #(.PB(PB)) u_pend_split (
    .grouping(grouping), .prio(pend_prio[7 -: PB]),
    .grp(pend_grp), .sub(pend_sub_unused)
  );

  pg_lane_split #(.PB(PB)) u_act_split (
    .grouping(grouping), .prio(act_prio[7 -: PB]),
    .grp(act_grp), .sub(act_sub_unused)
  );

  pg_preempt_cmp #(.PB(PB)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .act_valid(act_valid),
    .pend_grp(pend_grp), .act_grp(act_grp), .preempt(preempt)
  );

  assign vect_rst_pulse = strobe.vect_rst;
  assign clr_act_pulse  = strobe.clr_act;
  assign sys_rst_req    = strobe.sys_req;

  // R7: all-subpriority setting never preempts
  a_r7_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (grouping == 3'd7) |-> !preempt);

  // R5: with no subpriority bits, lane 0 subpriority is zero
  a_r5_nosub: assert property (@(posedge clk) disable iff (!rst_n)
    (grouping <= 3'd4) |-> (sub_word[PB-1:0] == '0));
endmodule

// File: tb/tb_prio_group_ctrl.sv
`timescale 1ns/1ps
module tb_prio_group_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_priv = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] prio_word = '0;
  logic [11:0] grp_word, sub_word;
  logic        pend_valid = 1'b0, act_valid = 1'b0;
  logic [7:0]  pend_prio = '0, act_prio = '0;
  logic        preempt, vect_rst_pulse, clr_act_pulse, sys_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_group_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_priv(reg_priv), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .prio_word(prio_word), .grp_word(grp_word), .sub_word(sub_word),
    .pend_valid(pend_valid), .pend_prio(pend_prio), .act_valid(act_valid),
    .act_prio(act_prio), .preempt(preempt), .vect_rst_pulse(vect_rst_pulse),
    .clr_act_pulse(clr_act_pulse), .sys_rst_req(sys_rst_req)
  );

  typedef struct packed {
    logic [2:0] g;
    logic [7:0] pend;
    logic [7:0] act;
    logic       exp_pre;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{3'd0, 8'h40, 8'h60, 1'b1},
    '{3'd4, 8'h1F, 8'h3F, 1'b1},
    '{3'd2, 8'hE0, 8'h00, 1'b0},
    '{3'd5, 8'h40, 8'h60, 1'b0},
    '{3'd5, 8'h20, 8'h40, 1'b1},
    '{3'd6, 8'h40, 8'h80, 1'b1},
    '{3'd6, 8'h20, 8'h40, 1'b0},
    '{3'd7, 8'h00, 8'hE0, 1'b0},
    '{3'd3, 8'hA0, 8'hA0, 1'b0},
    '{3'd6, 8'h7F, 8'hE0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic void exp_lane(input logic [2:0] g, input logic [2:0] p,
                                   output logic [2:0] gr, output logic [2:0] sb);
    case (g)
      3'd5: begin gr = {1'b0, p[2:1]}; sb = {2'b0, p[0]}; end
      3'd6: begin gr = {2'b0, p[2]};   sb = {1'b0, p[1:0]}; end
      3'd7: begin gr = 3'd0;           sb = p; end
      default: begin gr = p; sb = 3'd0; end
    endcase
  endfunction

  // drive at negedge, sample 1 ns after the capturing edge
  task automatic reg_write(input logic [31:0] d, input logic priv);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_priv = priv; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_priv = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic priv, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_priv = priv;
    #1 d = reg_rdata;
    reg_sel = 1'b0; reg_priv = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [2:0]  gr, sb;
    logic [11:0] eg, es;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R4, R2: reset value
    reg_read(1'b1, rd);
    chk("R4 reset readback", rd, 32'hFA05_0000);
    chk("R10 no pulse after reset", {29'b0, sys_rst_req, clr_act_pulse, vect_rst_pulse}, 32'h0);

    // vector table: program selector, then check split and preemption
    for (int k = 0; k < 10; k++) begin
      reg_write({16'h05FA, 5'b0, VEC[k].g, 8'h00}, 1'b1);
      @(negedge clk);
      pend_prio = VEC[k].pend; act_prio = VEC[k].act;
      pend_valid = 1'b1; act_valid = 1'b1;
      prio_word = {VEC[k].act, VEC[k].pend, ~VEC[k].act, ~VEC[k].pend};
      #1;
      chk("R9 preempt from table", {31'b0, preempt}, {31'b0, VEC[k].exp_pre});
      for (int l = 0; l < 4; l++) begin
        exp_lane(VEC[k].g, prio_word[8*l+5 +: 3], gr, sb);
        eg[3*l +: 3] = gr; es[3*l +: 3] = sb;
      end
      chk("R8 lane group split", {20'b0, grp_word}, {20'b0, eg});
      chk("R8 lane sub split", {20'b0, sub_word}, {20'b0, es});
    end

    // R5, R8: low bits of each lane have no effect
    reg_write(32'h05FA_0400, 1'b1);
    @(negedge clk) prio_word = 32'h1F1F_1F1F; #1;
    chk("R5 group ignores low bits", {20'b0, grp_word}, 32'h0);
    chk("R5 sub zero", {20'b0, sub_word}, 32'h0);
    @(negedge clk) prio_word = 32'hE0C0_A020; #1;
    chk("R8 lanes distinct", {20'b0, grp_word}, {20'b0, 3'd7, 3'd6, 3'd5, 3'd1});

    // R6: selector 6 on a known lane pattern
    reg_write(32'h05FA_0600, 1'b1);
    @(negedge clk) prio_word = 32'h0000_00E0; #1;
    chk("R6 grp at 6", {20'b0, grp_word}, 32'h1);
    chk("R6 sub at 6", {20'b0, sub_word}, 32'h3);

    // R7: flat setting, lowest vs highest never preempts
    reg_write(32'h05FA_0700, 1'b1);
    @(negedge clk) pend_prio = 8'h00; act_prio = 8'hE0; #1;
    chk("R7 flat no preempt", {31'b0, preempt}, 32'h0);
    chk("R7 flat sub", {20'b0, sub_word}, 32'h7);

    // R9: valid qualification
    reg_write(32'h05FA_0000, 1'b1);
    @(negedge clk) pend_prio = 8'h00; act_prio = 8'hE0; pend_valid = 1'b0; #1;
    chk("R9 no pending", {31'b0, preempt}, 32'h0);
    @(negedge clk) pend_valid = 1'b1; act_valid = 1'b0; #1;
    chk("R9 no active", {31'b0, preempt}, 32'h0);
    @(negedge clk) act_valid = 1'b1; #1;
    chk("R9 valid lower group", {31'b0, preempt}, 32'h1);

    // R1: bad key, no change and no pulse
    reg_write(32'h05FB_0507, 1'b1);
    chk("R1 bad key no pulse", {29'b0, sys_rst_req, clr_act_pulse, vect_rst_pulse}, 32'h0);
    reg_read(1'b1, rd);
    chk("R1 bad key ignored", rd, 32'hFA05_0000);

    // R3: unprivileged keyed write and read
    reg_write(32'h05FA_0507, 1'b0);
    chk("R3 unpriv no pulse", {29'b0, sys_rst_req, clr_act_pulse, vect_rst_pulse}, 32'h0);
    reg_read(1'b1, rd);
    chk("R3 unpriv write ignored", rd, 32'hFA05_0000);
    reg_read(1'b0, rd);
    chk("R3 unpriv read zero", rd, 32'h0);

    // R10: pulses last one cycle
    reg_write(32'h05FA_0505, 1'b1);
    chk("R10 pulse bits 0 and 2", {29'b0, sys_rst_req, clr_act_pulse, vect_rst_pulse}, 32'h5);
    @(posedge clk); #1;
    chk("R10 pulse ends", {29'b0, sys_rst_req, clr_act_pulse, vect_rst_pulse}, 32'h0);
    reg_write(32'h05FA_0502, 1'b1);
    chk("R10 clear-active pulse", {29'b0, sys_rst_req, clr_act_pulse, vect_rst_pulse}, 32'h2);

    // R2: reserved and endian bits read 0, strobes read 0
    reg_write(32'h05FA_FE07, 1'b1);
    reg_read(1'b1, rd);
    chk("R2 readback masks", rd, 32'hFA05_0600);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule